// File: doc/BRIEF.md
# Event-Input Time-Stamp Capture Unit

The unit watches one external event pin. When that pin holds its selected active level long enough to pass an optional debounce filter, the unit freezes a copy of the live time and calendar values (seconds through year) together with two supply-status flags. The copy lands in a bank of read-only registers. The same qualified event raises an event flag, and that flag can pull an open-drain interrupt line low.

A host reaches the unit through a simple register port. A write strobe commits on the clock edge, and reads are combinational from the address. A control register holds the capture enable, the active-level choice, the pull-up request bit, the interrupt enable and the debounce selection. A monitor register reports the event flag, the captured supply flags and the synchronized pin level. The debounce counter advances only on a sampling tick supplied from outside. The timing of the longest setting therefore follows the tick rate. At a 512 Hz tick, the longest setting is roughly 125 ms.

Top module: `evt_stamp_unit`

## Requirements
- R1: The snapshot registers read at 0x10 seconds, 0x11 minutes, 0x12 hours, 0x13 weekday, 0x14 day, 0x15 month and 0x16 year. Host writes to these addresses leave them unchanged.
- R2: A qualified event loads all seven live fields and both live supply flags into the snapshot on one clock edge. Without an event, the snapshot holds its value while the live inputs change.
- R3: The control register at 0x17 holds these fields: bit 7 capture enable, bit 6 active level (0 = low-active, 1 = high-active), bit 5 pull-up request (drives `pullup_en`), bit 2 interrupt enable, and bits 1:0 debounce select. Bits 4:3 read as 0, and the register resets to 0x00.
- R4: With debounce select 2'b00, an active level on the pin sets the event flag on the third rising clock edge after the pin changes. Two of those edges are the synchronizer stages.
- R5: With debounce select 2'b01, 2'b10 or 2'b11, the pin must stay active for DB_T1, DB_T2 or DB_T3 sampling ticks (defaults 4, 16 and 64). The flag then sets one edge after the last counted tick. A shorter active pulse is ignored, and clock cycles without a tick do not count.
- R6: Each active assertion of the pin yields at most one event. No new event is accepted until the synchronized pin has returned to its inactive level.
- R7: The event flag is monitor bit 5 at 0x18. Writing 0 to that bit clears the flag and writing 1 has no effect. If a clear write and a qualified event share a clock edge, the flag ends up set.
- R8: `irq_oe` is 1 exactly when the interrupt enable and the event flag are both 1, and `irq_out` is always 0. Clearing either bit releases `irq_oe` right after that write's clock edge.
- R9: While capture enable is 0, pin activity sets no flag and changes no snapshot.
- R10: Monitor register 0x18 reads bit 7 as the captured low-voltage flag, bit 6 as the captured voltage-detect flag, and bit 0 as the synchronized raw pin level before polarity. Its other bits read 0, and all bits are 0 after reset.
- R11: Reads of any address outside 0x10 to 0x18 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Debounce sampling tick, one cycle wide |
| evt_pin | input | 1 | Asynchronous external event input |
| live_sec | input | 8 | Live seconds from the clock core |
| live_min | input | 8 | Live minutes |
| live_hour | input | 8 | Live hours |
| live_wday | input | 8 | Live weekday |
| live_day | input | 8 | Live day of month |
| live_mon | input | 8 | Live month |
| live_year | input | 8 | Live year |
| live_vlow | input | 1 | Live low-voltage status flag |
| live_vdet | input | 1 | Live voltage-detect status flag |
| addr | input | 8 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, commits on the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq_oe | output | 1 | Interrupt driver enable (1 = pulling low) |
| irq_out | output | 1 | Interrupt data, constant 0 |
| pullup_en | output | 1 | Pull-up request bit from control |

## Verification
Pin changes are driven just after a falling edge. Without debounce, the flag is sampled at the falling edge after the second rising edge and expected clear. It is sampled again after the third rising edge and expected set. With debounce select 2'b01 and a tick every cycle, the flag must still read clear after N+2 rising edges and read set after N+3. Where the tick is withheld, the flag is due exactly one edge after the Nth tick-bearing edge. Register writes and their effect on `irq_oe`, `pullup_en` and the read data are checked at the falling edge right after the write edge, because reads are combinational. The same-edge race is provoked by placing a clear write on the third edge of a fresh pulse.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
    localparam int FW = 8;
    localparam int AW = 8;

    localparam logic [AW-1:0] A_SEC  = 8'h10;
    localparam logic [AW-1:0] A_MIN  = 8'h11;
    localparam logic [AW-1:0] A_HOUR = 8'h12;
    localparam logic [AW-1:0] A_WDAY = 8'h13;
    localparam logic [AW-1:0] A_DAY  = 8'h14;
    localparam logic [AW-1:0] A_MON  = 8'h15;
    localparam logic [AW-1:0] A_YEAR = 8'h16;
    localparam logic [AW-1:0] A_CTRL = 8'h17;
    localparam logic [AW-1:0] A_STAT = 8'h18;

    typedef struct packed {
        logic [FW-1:0] sec;
        logic [FW-1:0] min;
        logic [FW-1:0] hour;
        logic [FW-1:0] wday;
        logic [FW-1:0] day;
        logic [FW-1:0] mon;
        logic [FW-1:0] year;
    } cal_t;

    typedef struct packed {
        logic       cap_en;
        logic       act_high;
        logic       pull_en;
        logic       irq_en;
        logic [1:0] db_sel;
    } ctrl_t;
endpackage

// File: rtl/evt_pin_filter.sv
module evt_pin_filter #(
    parameter int DB_T1 = 4,
    parameter int DB_T2 = 16,
    parameter int DB_T3 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       pin,
    input  logic       enable,
    input  logic       act_high,
    input  logic [1:0] db_sel,
    output logic       fire,
    output logic       pin_lvl
);
    localparam int CW = $clog2(DB_T3 + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          armed;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t          flt_q, flt_d;
    logic          active;
    logic [CW-1:0] limit;

    always_comb begin
        case (db_sel)
            2'b01:   limit = CW'(DB_T1);
            2'b10:   limit = CW'(DB_T2);
            2'b11:   limit = CW'(DB_T3);
            default: limit = '0;
        endcase
        active = act_high ? flt_q.s2 : ~flt_q.s2;
        fire   = enable && flt_q.armed && active && (flt_q.cnt >= limit);

        flt_d    = flt_q;
        flt_d.s1 = pin;
        flt_d.s2 = flt_q.s1;
        if (!active) begin
            flt_d.armed = 1'b1;
            flt_d.cnt   = '0;
        end else begin
            if (fire) flt_d.armed = 1'b0;
            if (!enable) begin
                flt_d.cnt = '0;
            end else if (tick && (flt_q.cnt < limit)) begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign pin_lvl = flt_q.s2;
endmodule

// File: rtl/evt_snap_bank.sv
module evt_snap_bank
    import evt_stamp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  cal_t live,
    input  logic live_vlow,
    input  logic live_vdet,
    output cal_t snap,
    output logic snap_vlow,
    output logic snap_vdet
);
    typedef struct packed {
        cal_t t;
        logic vlow;
        logic vdet;
    } bank_t;

    bank_t bank_q, bank_d;

    always_comb begin
        bank_d = bank_q;
        if (capture) begin
            bank_d.t    = live;
            bank_d.vlow = live_vlow;
            bank_d.vdet = live_vdet;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign snap      = bank_q.t;
    assign snap_vlow = bank_q.vlow;
    assign snap_vdet = bank_q.vdet;
endmodule

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit
    import evt_stamp_pkg::*;
#(
    parameter int DB_T1 = 4,
    parameter int DB_T2 = 16,
    parameter int DB_T3 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       evt_pin,
    input  logic [7:0] live_sec,
    input  logic [7:0] live_min,
    input  logic [7:0] live_hour,
    input  logic [7:0] live_wday,
    input  logic [7:0] live_day,
    input  logic [7:0] live_mon,
    input  logic [7:0] live_year,
    input  logic       live_vlow,
    input  logic       live_vdet,
    input  logic [7:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq_oe,
    output logic       irq_out,
    output logic       pullup_en
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  ef;
    } top_t;

    top_t top_q, top_d;
    cal_t live_cal, snap_cal;
    logic evt_fire, pin_lvl, snap_vlow, snap_vdet;
    logic ef_flag, cap_on, irq_on;
    logic [7:0] snap_sec_w, snap_year_w;

    assign live_cal = '{sec: live_sec, min: live_min, hour: live_hour,
                        wday: live_wday, day: live_day, mon: live_mon,
                        year: live_year};

    evt_pin_filter #(.DB_T1(DB_T1), .DB_T2(DB_T2), .DB_T3(DB_T3)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pin      (evt_pin),
        .enable   (top_q.ctrl.cap_en),
        .act_high (top_q.ctrl.act_high),
        .db_sel   (top_q.ctrl.db_sel),
        .fire     (evt_fire),
        .pin_lvl  (pin_lvl)
    );

    evt_snap_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (evt_fire),
        .live      (live_cal),
        .live_vlow (live_vlow),
        .live_vdet (live_vdet),
        .snap      (snap_cal),
        .snap_vlow (snap_vlow),
        .snap_vdet (snap_vdet)
    );

    always_comb begin
        top_d = top_q;
        if (wr_en && (addr == A_CTRL)) begin
            top_d.ctrl.cap_en   = wr_data[7];
            top_d.ctrl.act_high = wr_data[6];
            top_d.ctrl.pull_en  = wr_data[5];
            top_d.ctrl.irq_en   = wr_data[2];
            top_d.ctrl.db_sel   = wr_data[1:0];
        end
        if (evt_fire) begin
            top_d.ef = 1'b1;
        end else if (wr_en && (addr == A_STAT) && !wr_data[5]) begin
            top_d.ef = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        case (addr)
            A_SEC:   rd_data = snap_cal.sec;
            A_MIN:   rd_data = snap_cal.min;
            A_HOUR:  rd_data = snap_cal.hour;
            A_WDAY:  rd_data = snap_cal.wday;
            A_DAY:   rd_data = snap_cal.day;
            A_MON:   rd_data = snap_cal.mon;
            A_YEAR:  rd_data = snap_cal.year;
            A_CTRL:  rd_data = {top_q.ctrl.cap_en, top_q.ctrl.act_high,
                                top_q.ctrl.pull_en, 2'b00, top_q.ctrl.irq_en,
                                top_q.ctrl.db_sel};
            A_STAT:  rd_data = {snap_vlow, snap_vdet, top_q.ef, 4'b0000, pin_lvl};
            default: rd_data = 8'h00;
        endcase
    end

    assign ef_flag     = top_q.ef;
    assign cap_on      = top_q.ctrl.cap_en;
    assign irq_on      = top_q.ctrl.irq_en;
    assign snap_sec_w  = snap_cal.sec;
    assign snap_year_w = snap_cal.year;

    assign irq_oe    = irq_on & ef_flag;
    assign irq_out   = 1'b0;
    assign pullup_en = top_q.ctrl.pull_en;
endmodule

// File: rtl/evt_stamp_unit_chk.sv
module evt_stamp_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fire,
    input logic       ef,
    input logic       cap_en,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic [7:0] wr_data,
    input logic       irq_oe,
    input logic [7:0] snap_sec,
    input logic [7:0] snap_year
);
    // R7: a qualified event always leaves the flag set
    assert_fire_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ef);

    // R2: snapshot only moves on an event
    assert_snap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(snap_sec) && $stable(snap_year)));

    // R6: one event per assertion of the pin
    assert_single_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R9: disabled capture never qualifies an event
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |-> !fire);

    // R8: a flag-clearing write without a competing event releases the line
    assert_irq_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 8'h18) && !wr_data[5] && !fire) |=> !irq_oe);
endmodule

bind evt_stamp_unit evt_stamp_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (evt_fire),
    .ef        (ef_flag),
    .cap_en    (cap_on),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .irq_oe    (irq_oe),
    .snap_sec  (snap_sec_w),
    .snap_year (snap_year_w)
);

// File: tb/evt_stamp_unit_test.sv
module evt_stamp_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       evt_pin = 1'b1;
    logic [7:0] live_sec = '0, live_min = '0, live_hour = '0, live_wday = '0;
    logic [7:0] live_day = '0, live_mon = '0, live_year = '0;
    logic       live_vlow = 1'b0, live_vdet = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_oe, irq_out, pullup_en;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] v;
    logic [7:0] exp_snap [7];

    always #5 clk = ~clk;

    evt_stamp_unit uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .evt_pin(evt_pin),
        .live_sec(live_sec), .live_min(live_min), .live_hour(live_hour),
        .live_wday(live_wday), .live_day(live_day), .live_mon(live_mon),
        .live_year(live_year), .live_vlow(live_vlow), .live_vdet(live_vdet),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_oe(irq_oe), .irq_out(irq_out), .pullup_en(pullup_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] o);
        addr = a;
        #1;
        o = rd_data;
    endtask

    task automatic ef_is(input string req, input logic expv);
        logic [7:0] t;
        rd(8'h18, t);
        chk(req, {7'b0, t[5]}, {7'b0, expv});
    endtask

    task automatic prep(input logic [7:0] c, input logic idle);
        wr(8'h17, 8'h00);
        evt_pin = idle;
        cyc(4);
        wr(8'h18, 8'h00);
        wr(8'h17, c);
    endtask

    task automatic t_reset;
        rd(8'h17, v); chk("R3 ctrl reset", v, 8'h00);
        rd(8'h18, v); chk("R10 monitor reset", v, 8'h00);
        rd(8'h10, v); chk("R1 snapshot reset", v, 8'h00);
        chk("R8 irq_oe reset", {7'b0, irq_oe}, 8'h00);
        chk("R3 pullup reset", {7'b0, pullup_en}, 8'h00);
        wr(8'h17, 8'hFF);
        rd(8'h17, v); chk("R3 ctrl readback", v, 8'hE7);
        chk("R3 pullup_en", {7'b0, pullup_en}, 8'h01);
        wr(8'h17, 8'h00);
        rd(8'h20, v); chk("R11 unmapped 0x20", v, 8'h00);
        rd(8'h0F, v); chk("R11 unmapped 0x0F", v, 8'h00);
    endtask

    task automatic t_nodebounce;
        prep(8'h84, 1'b1);
        live_sec = 8'h31; live_min = 8'h42; live_hour = 8'h13; live_wday = 8'h04;
        live_day = 8'h25; live_mon = 8'h06; live_year = 8'h27;
        live_vlow = 1'b1; live_vdet = 1'b0;
        exp_snap = '{8'h31, 8'h42, 8'h13, 8'h04, 8'h25, 8'h06, 8'h27};
        evt_pin = 1'b0;
        cyc(2);
        ef_is("R4 flag clear after two edges", 1'b0);
        cyc(1);
        ef_is("R4 flag set on third edge", 1'b1);
        chk("R8 irq_oe asserted", {7'b0, irq_oe}, 8'h01);
        chk("R8 irq_out low", {7'b0, irq_out}, 8'h00);
        for (int i = 0; i < 7; i++) begin
            rd(8'h10 + 8'(i), v);
            chk("R1 snapshot field order", v, exp_snap[i]);
        end
        rd(8'h18, v); chk("R10 captured supply flags", v & 8'hC0, 8'h80);
        live_sec = 8'h59; live_year = 8'h99; live_vlow = 1'b0; live_vdet = 1'b1;
        cyc(3);
        rd(8'h10, v); chk("R2 snapshot seconds hold", v, 8'h31);
        rd(8'h16, v); chk("R2 snapshot year hold", v, 8'h27);
        rd(8'h18, v); chk("R10 supply flags hold", v & 8'hC0, 8'h80);
        wr(8'h10, 8'h55);
        rd(8'h10, v); chk("R1 write to snapshot ignored", v, 8'h31);
        wr(8'h18, 8'h00);
        cyc(10);
        ef_is("R6 held pin gives no second event", 1'b0);
        evt_pin = 1'b1;
        cyc(4);
        evt_pin = 1'b0;
        cyc(3);
        ef_is("R6 re-armed after inactive", 1'b1);
        rd(8'h10, v); chk("R2 second capture", v, 8'h59);
    endtask

    task automatic t_release;
        chk("R8 irq_oe before release", {7'b0, irq_oe}, 8'h01);
        wr(8'h17, 8'h80);
        chk("R8 release by enable", {7'b0, irq_oe}, 8'h00);
        wr(8'h17, 8'h84);
        chk("R8 re-assert by enable", {7'b0, irq_oe}, 8'h01);
        wr(8'h18, 8'h00);
        chk("R8 release by flag clear", {7'b0, irq_oe}, 8'h00);
        ef_is("R7 flag cleared by write 0", 1'b0);
        wr(8'h18, 8'h20);
        ef_is("R7 write 1 has no effect", 1'b0);
    endtask

    task automatic t_race;
        prep(8'h84, 1'b1);
        evt_pin = 1'b0;
        cyc(3);
        ef_is("R7 race setup", 1'b1);
        evt_pin = 1'b1;
        cyc(4);
        evt_pin = 1'b0;
        cyc(2);
        addr = 8'h18; wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        ef_is("R7 event wins over clear", 1'b1);
    endtask

    task automatic t_debounce;
        prep(8'h85, 1'b1);
        evt_pin = 1'b0;
        cyc(6);
        ef_is("R5 select 01 not yet", 1'b0);
        cyc(1);
        ef_is("R5 select 01 fires", 1'b1);
        prep(8'h87, 1'b1);
        evt_pin = 1'b0;
        cyc(64);
        evt_pin = 1'b1;
        cyc(10);
        ef_is("R5 short pulse ignored", 1'b0);
        evt_pin = 1'b0;
        cyc(70);
        ef_is("R5 long pulse accepted", 1'b1);
        prep(8'h85, 1'b1);
        tick = 1'b0;
        evt_pin = 1'b0;
        cyc(50);
        ef_is("R5 no tick no count", 1'b0);
        tick = 1'b1;
        cyc(4);
        ef_is("R5 tick count not reached", 1'b0);
        cyc(1);
        ef_is("R5 tick count reached", 1'b1);
    endtask

    task automatic t_disabled;
        prep(8'h04, 1'b1);
        live_sec = 8'h07;
        evt_pin = 1'b0;
        cyc(20);
        ef_is("R9 disabled no flag", 1'b0);
        chk("R9 disabled no irq", {7'b0, irq_oe}, 8'h00);
        rd(8'h10, v); chk("R9 disabled snapshot unchanged", v, 8'h59);
    endtask

    task automatic t_polarity;
        prep(8'hC4, 1'b0);
        cyc(10);
        ef_is("R3 high-active ignores low", 1'b0);
        rd(8'h18, v); chk("R10 pin level low", v & 8'h01, 8'h00);
        evt_pin = 1'b1;
        cyc(2);
        rd(8'h18, v); chk("R10 pin level high", v & 8'h01, 8'h01);
        cyc(1);
        ef_is("R3 high-active event", 1'b1);
        rd(8'h10, v); chk("R3 capture on high level", v, 8'h07);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset;
        t_nodebounce;
        t_release;
        t_race;
        t_debounce;
        t_disabled;
        t_polarity;
        cyc(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule